// File: doc/BRIEF.md
# Pin-Requested Power-Down Hold Controller

This block freezes the boundary of a logic core while a power-down request is present. It sits on two paths. On the inward path it stands between the input pads and the core. On the outward path it stands between the core's output data and output-enable lines and the pad drivers. Two request pins can each ask for power-down, and either one is enough. When a request is seen, the block keeps the last input values it captured and presents them to the core. It drops the core's clock enable so that the core's registers keep their contents. It also drives the pads with the output data and enable values that were present at entry, so an output that was tristated stays tristated.

When both request pins have been low for long enough, a recovery counter runs. The hold stays in force until that counter has expired, and only then does normal operation resume. A strap input enables the feature for a given design. With the strap set, the request pins are hidden from the core. With the strap clear, no hold ever occurs and the two pins reach the core as ordinary logic inputs.

Top module: `pd_hold_ctrl`

## Requirements
- R1: After reset, core_in follows pad_in, pad_out and pad_oe follow core_out and core_oe, core_clk_en is 1 and pd_active is 0.
- R2: A hold is entered only while feat_en is 1 and at least one of req_a, req_b is high. With feat_en at 0, pd_active stays 0 whatever the request pins do.
- R3: Each request pin passes through a two-stage synchroniser. core_clk_en falls after the second rising clock edge that follows a request going high. pd_active rises after the third.
- R4: While the hold is in force, core_in keeps the pad_in value sampled on the last edge before the hold, and later pad_in changes have no effect on it.
- R5: While pd_active is 1, pad_out and pad_oe keep the core_out and core_oe values present at entry. An output whose enable bit was 0 at entry keeps its enable at 0.
- R6: core_clk_en is 0 from the first synchronised request sample until recovery is complete.
- R7: Once both synchronised requests are low, the hold lasts WAKE_CYCLES more cycles. With WAKE_CYCLES=8 and the request dropped before a clock edge, pd_active is still 1 after ten edges and is 0 after eleven, at which point core_clk_en is 1 and the pads follow the core again.
- R8: A request that returns during recovery puts the block back into hold, and pd_active does not drop in between.
- R9: With feat_en at 1, req_a_lg and req_b_lg are 0. With feat_en at 0, they equal req_a and req_b.
- R10: Whenever pd_active is 1, core_clk_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| feat_en | input | 1 | Design strap that enables power-down |
| req_a | input | 1 | First asynchronous power-down request pin |
| req_b | input | 1 | Second asynchronous power-down request pin |
| pad_in | input | IN_W | Values from the input pads |
| core_in | output | IN_W | Inputs presented to the core, held during power-down |
| req_a_lg | output | 1 | req_a as a core logic input, 0 when the feature is on |
| req_b_lg | output | 1 | req_b as a core logic input, 0 when the feature is on |
| core_clk_en | output | 1 | Core clock enable, 0 while state is frozen |
| core_out | input | OUT_W | Output data from the core |
| core_oe | input | OUT_W | Output enables from the core |
| pad_out | output | OUT_W | Output data to the pad drivers, held during power-down |
| pad_oe | output | OUT_W | Output enables to the pad drivers, held during power-down |
| pd_active | output | 1 | High from hold entry until recovery completes |

## Verification
The hardest case to reach from the ports is a request that comes back while the recovery counter is still running. It has to land inside a window whose position depends on the synchroniser delay and the counter length. The bench releases a steady hold, counts edges until the block must be in recovery, and then raises the other request pin. It watches pd_active on every cycle and confirms that the pads never leave the held values. The exact exit cycle is pinned down separately by counting edges from the release.

// File: rtl/pd_hold_pkg.sv
package pd_hold_pkg;
    typedef enum logic [1:0] {
        PD_RUN  = 2'd0,
        PD_HOLD = 2'd1,
        PD_WAKE = 2'd2
    } pd_state_e;
endpackage

// File: rtl/pd_req_sync.sv
module pd_req_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);
    for (genvar i = 0; i < N; i++) begin : g_chain
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_out[i] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/pd_seq.sv
module pd_seq
    import pd_hold_pkg::*;
#(
    parameter int WAKE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    output logic hold_now,
    output logic run_q,
    output logic active_q
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_CYCLES - 1);

    typedef struct packed {
        pd_state_e        st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            PD_RUN: begin
                if (pd_req) s_d.st = PD_HOLD;
            end
            PD_HOLD: begin
                if (!pd_req) begin
                    s_d.st  = PD_WAKE;
                    s_d.cnt = CNT_LOAD;
                end
            end
            PD_WAKE: begin
                if (pd_req)              s_d.st  = PD_HOLD;
                else if (s_q.cnt == '0)  s_d.st  = PD_RUN;
                else                     s_d.cnt = s_q.cnt - 1'b1;
            end
            default: s_d.st = PD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= PD_RUN;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run_q    = (s_q.st == PD_RUN);
    assign active_q = !run_q;
    assign hold_now = active_q || pd_req;
endmodule

// File: rtl/pd_hold_reg.sv
module pd_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic         use_held,
    input  logic [W-1:0] live_in,
    output logic [W-1:0] val_out
);
    logic [W-1:0] held_d, held_q;

    always_comb begin
        held_d = cap_en ? live_in : held_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign val_out = use_held ? held_q : live_in;
endmodule

// File: rtl/pd_hold_ctrl.sv
module pd_hold_ctrl #(
    parameter int IN_W        = 8,
    parameter int OUT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_CYCLES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_en,
    input  logic             req_a,
    input  logic             req_b,
    input  logic [IN_W-1:0]  pad_in,
    output logic [IN_W-1:0]  core_in,
    output logic             req_a_lg,
    output logic             req_b_lg,
    output logic             core_clk_en,
    input  logic [OUT_W-1:0] core_out,
    input  logic [OUT_W-1:0] core_oe,
    output logic [OUT_W-1:0] pad_out,
    output logic [OUT_W-1:0] pad_oe
    ,
    output logic             pd_active
);
    localparam int NREQ  = 2;
    localparam int OBUSW = 2 * OUT_W;

    logic [NREQ-1:0]  req_sync;
    logic             pd_req;
    logic             hold_now;
    logic             run_q;
    logic [OBUSW-1:0] obus_held;

    pd_req_sync #(.N(NREQ), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({req_b, req_a}),
        .sync_out (req_sync)
    );

    assign pd_req = feat_en && (|req_sync);

    pd_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pd_req   (pd_req),
        .hold_now (hold_now),
        .run_q    (run_q),
        .active_q (pd_active)
    );

    // Inward path freezes in the same cycle the clock enable drops.
    pd_hold_reg #(.W(IN_W)) u_in_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (!hold_now),
        .use_held (hold_now),
        .live_in  (pad_in),
        .val_out  (core_in)
    );

    // Outward path captures on the last running edge, when core state is final.
    pd_hold_reg #(.W(OBUSW)) u_out_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (run_q),
        .use_held (!run_q),
        .live_in  ({core_oe, core_out}),
        .val_out  (obus_held)
    );

    assign pad_out     = obus_held[OUT_W-1:0];
    assign pad_oe      = obus_held[OBUSW-1:OUT_W];
    assign core_clk_en = !hold_now;
    assign req_a_lg    = feat_en ? 1'b0 : req_a;
    assign req_b_lg    = feat_en ? 1'b0 : req_b;
endmodule

// File: rtl/pd_hold_ctrl_chk.sv
module pd_hold_ctrl_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             feat_en,
    input logic             req_a_lg,
    input logic             req_b_lg,
    input logic [IN_W-1:0]  core_in,
    input logic             core_clk_en,
    input logic [OUT_W-1:0] pad_out,
    input logic [OUT_W-1:0] pad_oe,
    input logic             pd_active
);
    assert_clk_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pd_active |-> !core_clk_en);

    assert_out_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && $past(pd_active)) |-> ($stable(pad_out) && $stable(pad_oe)));

    assert_in_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_clk_en && $past(!core_clk_en)) |-> $stable(core_in));

    assert_no_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!feat_en && !pd_active) |=> !pd_active);

    assert_req_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        feat_en |-> (!req_a_lg && !req_b_lg));

    assert_release_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd_active) |-> core_clk_en);
endmodule

bind pd_hold_ctrl pd_hold_ctrl_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .feat_en     (feat_en),
    .req_a_lg    (req_a_lg),
    .req_b_lg    (req_b_lg),
    .core_in     (core_in),
    .core_clk_en (core_clk_en),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pd_active   (pd_active)
);

// File: tb/pd_hold_ctrl_bench.sv
module pd_hold_ctrl_bench;
    localparam int W    = 8;
    localparam int WAKE = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         feat_en = 1'b1;
    logic         req_a = 1'b0;
    logic         req_b = 1'b0;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] core_in;
    logic         req_a_lg, req_b_lg, core_clk_en, pd_active;
    logic [W-1:0] core_out = '0;
    logic [W-1:0] core_oe = '0;
    logic [W-1:0] pad_out, pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pd_hold_ctrl #(.IN_W(W), .OUT_W(W), .SYNC_STAGES(2), .WAKE_CYCLES(WAKE)) u_pd_hold_ctrl (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .req_a(req_a), .req_b(req_b),
        .pad_in(pad_in), .core_in(core_in), .req_a_lg(req_a_lg), .req_b_lg(req_b_lg),
        .core_clk_en(core_clk_en), .core_out(core_out), .core_oe(core_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pd_active(pd_active)
    );

    typedef struct packed {
        logic         en, a, b;
        logic [W-1:0] in1, out1, oe1, in2, out2, oe2;
        logic [W-1:0] x_in, x_out, x_oe;
        logic         x_clk, x_act, x_rla, x_rlb;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{1'b1,1'b0,1'b0, 8'h11,8'h22,8'hFF, 8'h33,8'h44,8'hF0, 8'h33,8'h44,8'hF0, 1'b1,1'b0,1'b0,1'b0},
        '{1'b1,1'b1,1'b0, 8'h5A,8'hA5,8'h3C, 8'h00,8'hFF,8'hFF, 8'h5A,8'hA5,8'h3C, 1'b0,1'b1,1'b0,1'b0},
        '{1'b1,1'b0,1'b1, 8'h81,8'h7E,8'h00, 8'h18,8'hE7,8'hFF, 8'h81,8'h7E,8'h00, 1'b0,1'b1,1'b0,1'b0},
        '{1'b1,1'b1,1'b1, 8'hC3,8'h3C,8'h81, 8'h24,8'h42,8'h7E, 8'hC3,8'h3C,8'h81, 1'b0,1'b1,1'b0,1'b0},
        '{1'b0,1'b1,1'b1, 8'h0F,8'hF0,8'h55, 8'h96,8'h69,8'hAA, 8'h96,8'h69,8'hAA, 1'b1,1'b0,1'b1,1'b1},
        '{1'b0,1'b1,1'b0, 8'h12,8'h34,8'h56, 8'h78,8'h9A,8'hBC, 8'h78,8'h9A,8'hBC, 1'b1,1'b0,1'b1,1'b0}
    };

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic release_all();
        req_a = 1'b0; req_b = 1'b0; feat_en = 1'b1;
        tick(2 + WAKE + 8);
    endtask

    task automatic enter_hold();
        req_a = 1'b1;
        tick(6);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        pad_in = 8'hA1; core_out = 8'hB2; core_oe = 8'hC3;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 core_in", core_in, 8'hA1);
        chk("R1 pad_out", pad_out, 8'hB2);
        chk("R1 pad_oe", pad_oe, 8'hC3);
        chk("R1 clk_en", {7'd0, core_clk_en}, 8'd1);
        chk("R1 active", {7'd0, pd_active}, 8'd0);

        // Vector table: R2 R4 R5 R6 R9 R10
        for (int r = 0; r < 6; r++) begin
            feat_en = TBL[r].en; req_a = TBL[r].a; req_b = TBL[r].b;
            pad_in = TBL[r].in1; core_out = TBL[r].out1; core_oe = TBL[r].oe1;
            tick(16);
            pad_in = TBL[r].in2; core_out = TBL[r].out2; core_oe = TBL[r].oe2;
            tick(4);
            chk($sformatf("R4 row%0d core_in", r), core_in, TBL[r].x_in);
            chk($sformatf("R5 row%0d pad_out", r), pad_out, TBL[r].x_out);
            chk($sformatf("R5 row%0d pad_oe", r), pad_oe, TBL[r].x_oe);
            chk($sformatf("R6 row%0d clk_en", r), {7'd0, core_clk_en}, {7'd0, TBL[r].x_clk});
            chk($sformatf("R2 row%0d active", r), {7'd0, pd_active}, {7'd0, TBL[r].x_act});
            chk($sformatf("R9 row%0d req_lg", r), {6'd0, req_b_lg, req_a_lg},
                {6'd0, TBL[r].x_rlb, TBL[r].x_rla});
            release_all();
        end

        // R3 entry latency
        pad_in = 8'h3E; core_out = 8'h4D; core_oe = 8'h0F;
        tick(2);
        req_b = 1'b1;
        tick(1);
        chk("R3 clk_en after 1 edge", {7'd0, core_clk_en}, 8'd1);
        tick(1);
        chk("R3 clk_en after 2 edges", {7'd0, core_clk_en}, 8'd0);
        chk("R3 active after 2 edges", {7'd0, pd_active}, 8'd0);
        tick(1);
        chk("R3 active after 3 edges", {7'd0, pd_active}, 8'd1);
        chk("R10 clk_en while active", {7'd0, core_clk_en}, 8'd0);
        tick(4);

        // R7 recovery window
        req_b = 1'b0;
        core_out = 8'h99; core_oe = 8'hFF;
        tick(2 + WAKE);
        chk("R7 active at end of window", {7'd0, pd_active}, 8'd1);
        chk("R7 pad_out still held", pad_out, 8'h4D);
        chk("R7 clk_en still low", {7'd0, core_clk_en}, 8'd0);
        tick(1);
        chk("R7 active cleared", {7'd0, pd_active}, 8'd0);
        chk("R7 clk_en restored", {7'd0, core_clk_en}, 8'd1);
        chk("R7 pad_out live", pad_out, 8'h99);
        tick(4);

        // R8 request returns during recovery
        core_out = 8'h6C; core_oe = 8'h01;
        enter_hold();
        core_out = 8'h00; core_oe = 8'hFF;
        req_a = 1'b0;
        tick(5);
        req_b = 1'b1;
        for (int i = 0; i < 12; i++) begin
            tick(1);
            chk($sformatf("R8 active cycle %0d", i), {7'd0, pd_active}, 8'd1);
        end
        chk("R8 pad_out kept", pad_out, 8'h6C);
        chk("R8 pad_oe kept", pad_oe, 8'h01);
        release_all();
        chk("R8 resumed", {7'd0, pd_active}, 8'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule